// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full `2*WIDTH`-bit product. A single-cycle `start` strobe captures both operands while the block is idle. The multiplier operand is then consumed two bits per cycle. Each overlapping three-bit window is recoded into a signed digit in the range -2 to +2. The matching multiple of the multiplicand (zero, one times or twice, either added or subtracted) is applied to the upper part of a running partial product, and the whole partial product is then shifted right by two places with its sign carried along. Because only the multiples 0, ±a and ±2a occur, every multiple comes from a shift and an inversion, and no odd multiple has to be precomputed.

The run takes `WIDTH/2` step cycles. When the last step is done, `done` pulses for one cycle. From that pulse onward, `product` holds the result until the next accepted `start`. `WIDTH` must be even and at least 2. The default is 16.

Top module: `booth4_mul`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are 0 and `product` is 0 until the first accepted `start`.
- R2: A `start` sampled high while `busy` is 0 captures `mcand` and `mplier`, and `busy` reads 1 in the following cycle.
- R3: Each step recodes the window (upper, middle, lower) of multiplier bits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. The digit times the multiplicand is added to the upper partial product.
- R4: The lower bit of the first window, to the right of multiplier bit 0, is taken as 0.
- R5: `done` is high for exactly one cycle. It goes high after the `WIDTH/2`-th clock edge that follows the edge accepting `start`, and `busy` falls at that same edge.
- R6: When `done` is high, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value. This includes the case where either or both operands are the most negative value.
- R7: While the block is idle, `product` does not change until another `start` is accepted.
- R8: A `start` while `busy` is 1 is ignored. The running operation finishes with its own operands and its normal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Operand capture strobe, accepted only when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The bench aims at the most negative operand on either side and on both sides. A design with a too-narrow accumulator, or with a shift that fills with zeros, returns a wrongly signed or truncated product there. Multiplier patterns made of alternating bits, runs of ones, all ones and a lone set LSB exercise every window code. A swapped digit entry or a first window seeded with 1 shows up as a wrong product. A second `start` injected mid-run checks that neither the operands nor the latency change. The hold check catches an accumulator that keeps shifting after `done`.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // Recoded radix-4 digit: nz selects a nonzero multiple, dbl picks 2a over a,
  // neg subtracts the multiple.
  typedef struct packed {
    logic neg;
    logic dbl;
    logic nz;
  } bdigit_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bstate_t;

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0] trip,   // {x(i+1), x(i), x(i-1)}
  output bdigit_t    dig
);

  always_comb begin
    dig = '0;
    unique case (trip)
      3'b000, 3'b111: dig = '{neg: 1'b0, dbl: 1'b0, nz: 1'b0};
      3'b001, 3'b010: dig = '{neg: 1'b0, dbl: 1'b0, nz: 1'b1};
      3'b011:         dig = '{neg: 1'b0, dbl: 1'b1, nz: 1'b1};
      3'b100:         dig = '{neg: 1'b1, dbl: 1'b1, nz: 1'b1};
      3'b101, 3'b110: dig = '{neg: 1'b1, dbl: 1'b0, nz: 1'b1};
      default:        dig = '0;
    endcase
  end

endmodule

// File: rtl/booth4_multiple.sv
module booth4_multiple
  import booth4_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int ACC_W = WIDTH + 2
) (
  input  logic [WIDTH-1:0] a,
  input  bdigit_t          dig,
  output logic [ACC_W-1:0] addend,
  output logic             cin
);

  logic [ACC_W-1:0] a_ext;
  logic [ACC_W-1:0] mag;
  logic [ACC_W-1:0] sel;

  always_comb begin
    a_ext  = {{2{a[WIDTH-1]}}, a};
    mag    = dig.dbl ? {a_ext[ACC_W-2:0], 1'b0} : a_ext;
    sel    = dig.nz ? mag : '0;
    // subtraction: one's complement here, the +1 enters as adder carry-in
    addend = dig.neg ? ~sel : sel;
    cin    = dig.neg;
  end

endmodule

// File: rtl/booth4_datapath.sv
module booth4_datapath
  import booth4_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int ACC_W = WIDTH + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0] a_q, a_d;
  logic [ACC_W-1:0] hi_q, hi_d;
  logic [WIDTH-1:0] lo_q, lo_d;
  logic             prev_q, prev_d;
  logic             en;

  bdigit_t          dig;
  logic [ACC_W-1:0] addend;
  logic             cin;
  logic [ACC_W-1:0] sum;
  logic [WIDTH+1:0] lo_cat;

  booth4_recoder u_rec (
    .trip ({lo_q[1], lo_q[0], prev_q}),
    .dig  (dig)
  );

  booth4_multiple #(.WIDTH(WIDTH)) u_mult (
    .a      (a_q),
    .dig    (dig),
    .addend (addend),
    .cin    (cin)
  );

  assign en = load | step;

  always_comb begin
    sum    = hi_q + addend + {{(ACC_W-1){1'b0}}, cin};
    lo_cat = {sum[1:0], lo_q};
    if (load) begin
      a_d    = mcand;
      hi_d   = '0;
      lo_d   = mplier;
      prev_d = 1'b0;            // implicit bit right of the LSB
    end else begin
      a_d    = a_q;
      hi_d   = {{2{sum[ACC_W-1]}}, sum[ACC_W-1:2]};   // arithmetic shift by two
      lo_d   = lo_cat[WIDTH+1:2];
      prev_d = lo_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      prev_q <= 1'b0;
    end else if (en) begin
      a_q    <= a_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      prev_q <= prev_d;
    end
  end

  assign product = {hi_q[WIDTH-1:0], lo_q};

endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl
  import booth4_pkg::*;
#(
  parameter int STEPS = 8,
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  bstate_t          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             last;

  always_comb begin
    load    = (state_q == ST_IDLE) && start;
    step    = (state_q == ST_RUN);
    last    = step && (cnt_q == LAST);
    state_d = state_q;
    if (load)      state_d = ST_RUN;
    else if (last) state_d = ST_IDLE;
    cnt_d   = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
    done_d  = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load | step) cnt_q <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul #(
  parameter int WIDTH = 16,
  localparam int STEPS = WIDTH / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load;
  logic       step;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  booth4_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .step    (step),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk #(
  parameter int WIDTH = 16,
  localparam int STEPS = WIDTH / 2,
  localparam int CW = $clog2(STEPS + 2) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0]   mc_q, mp_q;
  logic [CW-1:0]      run_q;
  logic [2*WIDTH-1:0] exp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q  <= '0;
      mp_q  <= '0;
      run_q <= '0;
    end else if (start && !busy) begin
      mc_q  <= mcand;
      mp_q  <= mplier;
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign exp_w = $signed({{WIDTH{mc_q[WIDTH-1]}}, mc_q}) *
                 $signed({{WIDTH{mp_q[WIDTH-1]}}, mp_q});

  // R5: one-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: latency counted in busy cycles
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q == CW'(STEPS)) && !busy);

  // R6: result matches captured operands
  p_product_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == exp_w);

  // R7: idle means frozen result
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(product));

  // R8: start during a run does not end or restart it early
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

endmodule

bind booth4_mul booth4_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/booth4_mul_bench.sv
module booth4_mul_bench;

  localparam int W     = 16;
  localparam int STEPS = W / 2;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   mcand;
  logic [W-1:0]   mplier;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_fail   = 0;

  booth4_mul #(.WIDTH(W)) u_booth4_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa, pb, pr;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pr = pa * pb;
    return pr[2*W-1:0];
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_up;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // one multiplication; inject>0 pulses a stray start at that cycle of the run
  task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input int inject);
    logic [2*W-1:0] exp_p;
    logic [2*W-1:0] held;
    int lat;
    bit seen;
    exp_p = ref_mul(a, b);
    @(negedge clk);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 64'(busy), 64'(1));
    lat  = 1;
    seen = 0;
    while (!seen && lat < 40) begin
      if (done) seen = 1;
      else begin
        if (inject > 0 && lat == inject) begin
          mcand  = ~a;
          mplier = b ^ 16'h5A5A;
          start  = 1'b1;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        lat++;
      end
    end
    start = 1'b0;
    check("R5 latency", 64'(lat), 64'(STEPS + 1));
    check("R5 busy low at done", 64'(busy), 64'(0));
    check(inject > 0 ? "R8 product after stray start" : "R6 product", 64'(product), 64'(exp_p));
    held = product;
    @(negedge clk);
    check("R5 done one cycle", 64'(done), 64'(0));
    @(negedge clk);
    @(negedge clk);
    check("R7 product held", 64'(product), 64'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd20240611));
    rst_n  = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 busy in reset", 64'(busy), 64'(0));
    check("R1 done in reset", 64'(done), 64'(0));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'(0));
    check("R1 product after reset", 64'(product), 64'(0));

    // R6 corner cases: most negative operands
    do_mul(16'h8000, 16'h8000, 0);
    do_mul(16'h8000, 16'h7FFF, 0);
    do_mul(16'h7FFF, 16'h8000, 0);
    do_mul(16'h7FFF, 16'h7FFF, 0);
    do_mul(16'h0000, 16'h8000, 0);
    // R3 window codes: alternating bits, runs of ones, all ones
    do_mul(16'h1234, 16'h5555, 0);
    do_mul(16'hF00D, 16'hAAAA, 0);
    do_mul(16'h0ABC, 16'h6666, 0);
    do_mul(16'h9999, 16'h3333, 0);
    do_mul(16'h4321, 16'hFFFF, 0);
    do_mul(16'hFFFF, 16'hFFFF, 0);
    // R4: lone LSB must yield exactly the multiplicand
    do_mul(16'h2468, 16'h0001, 0);
    do_mul(16'hC001, 16'h0003, 0);
    // R8: stray start mid-run
    do_mul(16'h1357, 16'hBEEF, 3);
    do_mul(16'h8000, 16'h8001, 1);

    for (int i = 0; i < 150; i++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      do_mul(ra, rb, (i % 10 == 0) ? 4 : 0);
    end
    finish_up();
  end

endmodule